// File: doc/BRIEF.md
# Speculative Fast-Path Load Latency Controller

This block sits at the address-generation step of a single load port. It accepts at most one load per cycle. Each load carries a tag, a base register value, a signed displacement, a flag for the indexed addressing form, and a flag telling whether the base value was delivered by an earlier load rather than by an arithmetic unit. For loads that qualify, the block guesses that the final address lies in the same 4 KiB page as the base. That guess lets the cache and translation lookup start one cycle early, before the adder has finished. The block then checks the guess against the real sum and picks one of three outcomes: a short completion, the ordinary completion, or a replay with a long penalty.

A single history bit stops repeated failures from piling up. After a guess fails, the next qualifying load is sent down the ordinary path, and the one after it may guess again. Loads in flight are held in an age-ordered shift pipeline of completion slots. The block raises a one-cycle done pulse, with the tag and the path taken, in the exact cycle the load completes. When a younger load's target cycle is already claimed by an older load, the older load keeps its cycle and the younger one moves to the first free later cycle.

Top module: `flp_load_latency_ctrl`

## Requirements
- R1: A load on the ordinary path reports done exactly 5 cycles after the cycle in which it was presented, with path code 0 (ordinary).
- R2: A qualifying load whose final address stays in the base's page reports done 4 cycles after it was presented, with path code 1 (fast).
- R3: A load qualifies only if displacement bits [31:11] are all zero. So 0 to 2047 qualify, while 2048 and any negative displacement take the ordinary path.
- R4: A load with the indexed flag set always takes the ordinary path.
- R5: A load whose base-from-load flag is clear always takes the ordinary path.
- R6: A qualifying load whose sum differs from its base in address bits [47:12] is replayed. It reports done 10 cycles after it was presented, with path code 2 (replay).
- R7: After a replay, the next qualifying load is forced onto the ordinary path and clears the history bit. Non-qualifying loads in between leave the bit set. The qualifying load after the forced one may take the fast path again.
- R8: A dependent chain in which every load crosses a page, each issued in the cycle after the previous one completes, shows latencies 10, 5, 10, 5, which is 7.5 cycles per load on average.
- R9: When a load's completion cycle is already held by an older load, the older load completes unchanged and the younger one completes in the first later free cycle, keeping its path code.
- R10: The done pulse lasts one cycle per load and carries that load's tag; no done is reported in any other cycle.
- R11: Reset empties all in-flight loads, so none of them reports done, and clears the history bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_tag | input | 6 | Identifier of the presented load |
| ld_base | input | 48 | Base register value |
| ld_disp | input | 32 | Signed displacement |
| ld_indexed | input | 1 | Load uses the indexed addressing form |
| ld_base_from_load | input | 1 | Base value was produced by an earlier load |
| done_valid | output | 1 | A load completes this cycle |
| done_tag | output | 6 | Tag of the completing load |
| done_path | output | 2 | Path taken: 0 ordinary, 1 fast, 2 replay |

## Verification
A fast-path load and an older ordinary load can aim at the same completion cycle. So can an ordinary load and an older replay. The bench forces the first case on purpose: it presents an indexed load and a fast-eligible load in back-to-back cycles. It then checks that the older tag appears in its own cycle and the younger one cycle later, still marked fast. A long random back-to-back stream produces many more such collisions. In every cycle that stream is judged against a behavioural model that reserves completion cycles in a table.

// File: rtl/flp_pkg.sv
package flp_pkg;

    parameter int ADDR_W     = 48;
    parameter int DISP_W     = 32;
    parameter int TAG_W      = 6;
    parameter int PAGE_SHIFT = 12;
    parameter int SHORT_BITS = 11;
    parameter int LAT_FAST   = 4;
    parameter int LAT_NORMAL = 5;
    parameter int LAT_REPLAY = 10;

    localparam int DEPTH = LAT_REPLAY;

    typedef enum logic [1:0] {
        PATH_NORMAL = 2'd0,
        PATH_FAST   = 2'd1,
        PATH_REPLAY = 2'd2
    } path_e;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        path_e            path;
    } slot_t;

    function automatic logic short_disp(input logic [DISP_W-1:0] d);
        return d[DISP_W-1:SHORT_BITS] == '0;
    endfunction

    function automatic logic same_page(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] b);
        return a[ADDR_W-1:PAGE_SHIFT] == b[ADDR_W-1:PAGE_SHIFT];
    endfunction

    function automatic int lat_of(input path_e p);
        case (p)
            PATH_FAST:   return LAT_FAST;
            PATH_REPLAY: return LAT_REPLAY;
            default:     return LAT_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/flp_path_select.sv
module flp_path_select
    import flp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        base,
    input  logic signed [DISP_W-1:0] disp,
    input  logic                     indexed,
    input  logic                     base_from_load,
    output path_e                    path
);

    logic              suppress_q;
    logic              suppress_d;
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] eff_addr;
    logic              eligible;
    logic              crosses;

    assign disp_ext = ADDR_W'(disp);
    assign eff_addr = base + disp_ext;
    assign eligible = !indexed && base_from_load && short_disp(disp);
    assign crosses  = !same_page(base, eff_addr);

    always_comb begin
        if (!eligible || suppress_q) begin
            path = PATH_NORMAL;
        end else if (crosses) begin
            path = PATH_REPLAY;
        end else begin
            path = PATH_FAST;
        end
    end

    always_comb begin
        suppress_d = suppress_q;
        if (req_valid && eligible) begin
            suppress_d = suppress_q ? 1'b0 : crosses;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            suppress_q <= 1'b0;
        end else begin
            suppress_q <= suppress_d;
        end
    end

    // R3 R4 R5: a guess is only made for qualifying loads
    a_r3_gate_only_qualified: assert property (@(posedge clk) disable iff (rst)
        (req_valid && path != PATH_NORMAL) |->
            (disp[DISP_W-1:SHORT_BITS] == '0 && !indexed && base_from_load));

    // R7: a replay arms the history bit
    a_r7_replay_arms: assert property (@(posedge clk) disable iff (rst)
        (req_valid && path == PATH_REPLAY) |=> suppress_q);

    // R7: an armed history bit is spent by the next qualifying load
    a_r7_forced_clears: assert property (@(posedge clk) disable iff (rst)
        (req_valid && eligible && suppress_q) |=> !suppress_q);

    // R11: reset leaves the history bit clear
    a_r11_history_reset: assert property (@(posedge clk)
        rst |=> !suppress_q);

endmodule

// File: rtl/flp_completion_pipe.sv
module flp_completion_pipe
    import flp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_valid,
    input  logic [TAG_W-1:0] ins_tag,
    input  path_e            ins_path,
    output logic             done_valid,
    output logic [TAG_W-1:0] done_tag,
    output path_e            done_path
);

    localparam int IDX_W = $clog2(DEPTH);

    slot_t            stage_q [DEPTH];
    slot_t            stage_d [DEPTH];
    slot_t            shifted [DEPTH];
    logic [IDX_W-1:0] pick;
    logic             found;
    int               start;

    for (genvar i = 0; i < DEPTH; i++) begin : g_shift
        if (i < DEPTH - 1) begin : g_mid
            assign shifted[i] = stage_q[i+1];
        end else begin : g_top
            assign shifted[i] = '0;
        end
    end

    always_comb begin
        start = lat_of(ins_path) - 1;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && i >= start && !shifted[i].valid) begin
                found = 1'b1;
                pick  = IDX_W'(i);
            end
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            stage_d[i] = shifted[i];
        end
        if (ins_valid && found) begin
            stage_d[pick] = '{valid: 1'b1, tag: ins_tag, path: ins_path};
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                stage_q[i] <= '0;
            end else begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign done_valid = stage_q[0].valid;
    assign done_tag   = stage_q[0].tag;
    assign done_path  = stage_q[0].path;

    // R9: every accepted load obtains a completion slot
    a_r9_slot_found: assert property (@(posedge clk) disable iff (rst)
        ins_valid |-> found);

    // R9: an older load never changes its completion cycle
    for (genvar i = 0; i < DEPTH - 1; i++) begin : g_hold
        a_r9_no_move: assert property (@(posedge clk) disable iff (rst)
            stage_q[i+1].valid |=>
                (stage_q[i].valid && stage_q[i].tag == $past(stage_q[i+1].tag)
                 && stage_q[i].path == $past(stage_q[i+1].path)));
    end

    // R11: nothing completes right after reset
    a_r11_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !done_valid);

endmodule

// File: rtl/flp_load_latency_ctrl.sv
module flp_load_latency_ctrl
    import flp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ld_valid,
    input  logic [TAG_W-1:0]         ld_tag,
    input  logic [ADDR_W-1:0]        ld_base,
    input  logic signed [DISP_W-1:0] ld_disp,
    input  logic                     ld_indexed,
    input  logic                     ld_base_from_load,
    output logic                     done_valid,
    output logic [TAG_W-1:0]         done_tag,
    output logic [1:0]               done_path
);

    path_e sel_path;
    path_e out_path;

    flp_path_select u_select (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (ld_valid),
        .base           (ld_base),
        .disp           (ld_disp),
        .indexed        (ld_indexed),
        .base_from_load (ld_base_from_load),
        .path           (sel_path)
    );

    flp_completion_pipe u_pipe (
        .clk        (clk),
        .rst        (rst),
        .ins_valid  (ld_valid),
        .ins_tag    (ld_tag),
        .ins_path   (sel_path),
        .done_valid (done_valid),
        .done_tag   (done_tag),
        .done_path  (out_path)
    );

    assign done_path = out_path;

    // R10: an idle output carries no path other than the reset encoding
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !done_valid |-> done_path == 2'd0);

endmodule

// File: tb/flp_load_latency_ctrl_bench.sv
`timescale 1ns/1ps
module flp_load_latency_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_valid = 1'b0;
    logic [5:0]  ld_tag = '0;
    logic [47:0] ld_base = '0;
    logic [31:0] ld_disp = '0;
    logic        ld_indexed = 1'b0;
    logic        ld_base_from_load = 1'b0;
    logic        done_valid;
    logic [5:0]  done_tag;
    logic [1:0]  done_path;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    bit [5:0] exp_tag  [int];
    bit [1:0] exp_path [int];
    bit       sup = 1'b0;

    always #2.5 clk = ~clk;

    flp_load_latency_ctrl u_flp_load_latency_ctrl (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_tag(ld_tag),
        .ld_base(ld_base), .ld_disp(ld_disp), .ld_indexed(ld_indexed),
        .ld_base_from_load(ld_base_from_load), .done_valid(done_valid),
        .done_tag(done_tag), .done_path(done_path)
    );

    // Behavioural reference: decide path, reserve first free completion cycle
    always @(posedge clk) begin
        if (rst) begin
            exp_tag.delete();
            exp_path.delete();
            sup = 1'b0;
        end else if (ld_valid) begin
            int d;
            bit elig;
            bit [1:0] p;
            int lat;
            int t;
            d = $signed(ld_disp);
            elig = !ld_indexed && ld_base_from_load && d >= 0 && d < 2048;
            if (elig && sup) begin
                p = 2'd0; sup = 1'b0;
            end else if (elig) begin
                if ((ld_base >> 12) != ((ld_base + 48'(d)) >> 12)) begin
                    p = 2'd2; sup = 1'b1;
                end else begin
                    p = 2'd1;
                end
            end else begin
                p = 2'd0;
            end
            lat = (p == 2'd1) ? 4 : (p == 2'd2) ? 10 : 5;
            t = cyc + lat;
            while (exp_tag.exists(t)) t++;
            exp_tag[t]  = ld_tag;
            exp_path[t] = p;
        end
        cyc = cyc + 1;
    end

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst) begin
            bit e;
            e = exp_tag.exists(cyc);
            if (e || done_valid) begin
                checks++;
                if (!e || !done_valid || done_tag != exp_tag[cyc] || done_path != exp_path[cyc]) begin
                    fails++;
                    $display("FAIL R10 cycle %0d: got valid=%0b tag=%0d path=%0d expected valid=%0b tag=%0d path=%0d",
                             cyc, done_valid, done_tag, done_path, e,
                             e ? exp_tag[cyc] : 6'd0, e ? exp_path[cyc] : 2'd0);
                end
            end
            if (e) begin
                exp_tag.delete(cyc);
                exp_path.delete(cyc);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: got cycle %0d expected completion before 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string rq, input int got, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", rq, got, expv);
        end
    endtask

    task automatic drive(input [5:0] tg, input [47:0] b, input int d, input bit ix, input bit fl);
        ld_valid = 1'b1; ld_tag = tg; ld_base = b; ld_disp = 32'(d);
        ld_indexed = ix; ld_base_from_load = fl;
    endtask

    task automatic measure(input [5:0] tg, input [47:0] b, input int d, input bit ix,
                           input bit fl, input int exp_lat, input [1:0] exp_p,
                           input string rq, output int lat);
        int k;
        @(negedge clk);
        drive(tg, b, d, ix, fl);
        k = cyc;
        @(negedge clk);
        ld_valid = 1'b0;
        while (!done_valid && cyc - k < 40) @(negedge clk);
        lat = cyc - k;
        check(lat == exp_lat, {rq, " latency"}, lat, exp_lat);
        check(done_path == exp_p && done_tag == tg, {rq, " path"}, done_path, exp_p);
    endtask

    initial begin
        int lat;
        int sum;
        int k;
        repeat (3) @(negedge clk);
        check(done_valid == 1'b0, "R11 reset idle", done_valid, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done_valid == 1'b0, "R11 idle after reset", done_valid, 0);

        measure(6'd1, 48'h1000, 16, 1'b0, 1'b1, 4, 2'd1, "R2", lat);
        measure(6'd2, 48'h1000, 2047, 1'b0, 1'b1, 4, 2'd1, "R3 disp 2047", lat);
        measure(6'd3, 48'h1000, 2048, 1'b0, 1'b1, 5, 2'd0, "R3 disp 2048", lat);
        measure(6'd4, 48'h1800, -8, 1'b0, 1'b1, 5, 2'd0, "R3 negative", lat);
        measure(6'd5, 48'h1000, 16, 1'b1, 1'b1, 5, 2'd0, "R4 indexed", lat);
        measure(6'd6, 48'h1000, 16, 1'b0, 1'b0, 5, 2'd0, "R5 alu base", lat);
        measure(6'd7, 48'h1000, 16, 1'b1, 1'b0, 5, 2'd0, "R1 ordinary", lat);

        // R6 then R7: non-qualifying load leaves history armed
        measure(6'd8, 48'h1FF0, 32, 1'b0, 1'b1, 10, 2'd2, "R6 replay", lat);
        measure(6'd9, 48'h2000, 8, 1'b1, 1'b1, 5, 2'd0, "R7 ineligible between", lat);
        measure(6'd10, 48'h2000, 8, 1'b0, 1'b1, 5, 2'd0, "R7 forced ordinary", lat);
        measure(6'd11, 48'h2000, 8, 1'b0, 1'b1, 4, 2'd1, "R7 fast again", lat);

        // R8: page-crossing chain
        sum = 0;
        for (int i = 0; i < 4; i++) begin
            measure(6'(20 + i), 48'h3FFC, 100, 1'b0, 1'b1, (i % 2 == 0) ? 10 : 5,
                    (i % 2 == 0) ? 2'd2 : 2'd0, "R8 chain", lat);
            sum += lat;
        end
        check(sum * 2 == 15 * 4, "R8 average x2", sum * 2, 60);

        // R9: ordinary then fast in back-to-back cycles collide on the same cycle
        @(negedge clk);
        drive(6'd30, 48'h5000, 4, 1'b1, 1'b1);
        k = cyc;
        @(negedge clk);
        drive(6'd31, 48'h5000, 4, 1'b0, 1'b1);
        @(negedge clk);
        ld_valid = 1'b0;
        while (cyc < k + 5) @(negedge clk);
        check(done_valid && done_tag == 6'd30 && done_path == 2'd0, "R9 older keeps cycle", done_tag, 30);
        @(negedge clk);
        check(done_valid && done_tag == 6'd31 && done_path == 2'd1, "R9 younger next cycle", done_tag, 31);
        @(negedge clk);
        check(!done_valid, "R10 single pulse", done_valid, 0);

        // R11: reset mid-flight drops loads and clears history
        @(negedge clk);
        drive(6'd40, 48'h6FF8, 64, 1'b0, 1'b1);
        @(negedge clk);
        ld_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        k = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (done_valid) k++;
        end
        check(k == 0, "R11 flushed", k, 0);
        measure(6'd41, 48'h6FF8, 64, 1'b0, 1'b1, 10, 2'd2, "R11 history cleared", lat);

        // Random back-to-back stream judged by the model (R1 R2 R6 R7 R9 R10)
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) != 0) begin
                int d;
                bit [47:0] b;
                b = {36'($urandom), 12'($urandom_range(0, 4095))};
                if ($urandom_range(0, 1) == 1) b[11:0] = 12'hF00 | 12'($urandom_range(0, 255));
                case ($urandom_range(0, 4))
                    0: d = -int'($urandom_range(1, 300));
                    1: d = int'($urandom_range(2048, 5000));
                    default: d = int'($urandom_range(0, 2047));
                endcase
                drive(6'(i), b, d, $urandom_range(0, 5) == 0, $urandom_range(0, 5) != 0);
            end else begin
                ld_valid = 1'b0;
            end
        end
        @(negedge clk);
        ld_valid = 1'b0;
        repeat (30) @(negedge clk);
        check(exp_tag.num() == 0, "R10 all completed", exp_tag.num(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule